// File: doc/BRIEF.md
# Quad-Channel DAC Serial Command Loader

This block is the digital front end of a four-channel digital-to-analog converter. A host sends 24-bit command words over a three-wire serial link made of chip select, shift clock and data. Each word carries a 2-bit channel address, a broadcast flag and a 16-bit code. The block oversamples all pins on a fast system clock. Each pin passes through a two-flop synchronizer, and edges are detected on the synchronized copies. For that reason the system clock must run at least four times faster than the serial clock.

The shift register advances on every rising edge of the OR of chip select and the serial clock. The two pins are therefore interchangeable. If chip select rises while the serial clock is low, the shift register takes one extra bit, and the block keeps that behaviour.

Storage is double-buffered. An active-low load strobe makes the per-channel input registers follow the live shift register. A rising edge on the update strobe copies all four input registers into the output registers in a single cycle. A separate active-low clear pin zeroes both register banks and leaves the shift register alone.

Top module: `quad_dac_loader`

## Requirements
- R1: Bits 23:22 of the word select the channel (00 to 11 map to channel 0 to 3). Bits 15:0 are the code, sent MSB first, and channel n appears on code_o[16n+15:16n]. Bits 20:16 have no effect.
- R2: When bit 21 (broadcast) of the shift register is 1 during a load, all four input registers take the code.
- R3: The shift register advances by one bit on each rising edge of (cs_i OR sclk_i). It takes sdi_i into bit 0, and shift_o shows its 24 bits.
- R4: While cs_i stays high, toggling sclk_i leaves the shift register unchanged.
- R5: If cs_i rises while sclk_i is low, the shift register takes exactly one extra bit.
- R6: While load_ni is low, the selected input register or registers follow the shift register after every bit. Channels selected part-way through a transfer are therefore overwritten.
- R7: The outputs change only on a rising edge of ldac_i, and then all four input registers are copied at once.
- R8: While clr_ni is low, all input and output registers read 0000h. Neither the low level nor the rising edge of clr_ni changes the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cs_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data |
| load_ni | input | 1 | Active-low level load into input registers |
| ldac_i | input | 1 | Output update, rising-edge active |
| clr_ni | input | 1 | Active-low clear of input and output registers |
| code_o | output | 64 | Four 16-bit output codes, channel 0 in the low bits |
| shift_o | output | 24 | Shift register contents (debug) |

## Verification
A shift register holding a wrong bit, for example from a missed or extra combined-clock edge, shows on shift_o about three system cycles after the serial edge. A wrongly selected or corrupted input register stays hidden until the next ldac_i rising edge. It then shows on code_o three cycles later, so every channel is compared after each update pulse. A clear that does not reach a register, or an update that is missed, shows on code_o within four cycles of the strobe.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  parameter int unsigned WORD_W    = 24;
  parameter int unsigned CODE_W    = 16;
  parameter int unsigned CH_N      = 4;
  parameter int unsigned ADDR_W    = $clog2(CH_N);
  parameter int unsigned ADDR_LSB  = WORD_W - ADDR_W;
  parameter int unsigned BCAST_BIT = ADDR_LSB - 1;
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/qdl_shifter.sv
module qdl_shifter
  import qdl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] sh_o
);
  logic comb_clk, comb_q, rise;
  logic [WORD_W-1:0] sh_q;

  assign comb_clk = cs_i | sclk_i;
  assign rise     = comb_clk & ~comb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comb_q <= 1'b1;
      sh_q   <= '0;
    end else begin
      comb_q <= comb_clk;
      if (rise) sh_q <= {sh_q[WORD_W-2:0], sdi_i};
    end
  end
  assign sh_o = sh_q;

  // R4
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && $past(cs_i)) |=> $stable(sh_q));
  // R3
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_clk && !$past(comb_clk)) |=> (sh_q[0] == $past(sdi_i)));
endmodule

// File: rtl/qdl_bank.sv
module qdl_bank
  import qdl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [WORD_W-1:0]             sh_i,
  input  logic                          load_ni,
  input  logic                          ldac_i,
  input  logic                          clr_ni,
  output logic [CH_N-1:0][CODE_W-1:0]   out_o
);
  logic [CH_N-1:0][CODE_W-1:0] in_q, out_q;
  logic [ADDR_W-1:0] addr;
  logic bcast, ldac_q, upd;

  assign addr  = sh_i[WORD_W-1 -: ADDR_W];
  assign bcast = sh_i[BCAST_BIT];
  assign upd   = ldac_i & ~ldac_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic sel;
    assign sel = bcast || (addr == ADDR_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q[c]  <= '0;
        out_q[c] <= '0;
      end else if (!clr_ni) begin
        in_q[c]  <= '0;
        out_q[c] <= '0;
      end else begin
        if (!load_ni && sel) in_q[c] <= sh_i[CODE_W-1:0];
        if (upd) out_q[c] <= in_q[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ldac_q <= 1'b0;
    else         ldac_q <= ldac_i;
  end
  assign out_o = out_q;

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !(ldac_i && !$past(ldac_i))) |=> $stable(out_q));
  // R7
  out_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && ldac_i && !$past(ldac_i)) |=> (out_q == $past(in_q)));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (in_q == '0 && out_q == '0));
  // R6
  in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && clr_ni) |=> $stable(in_q));
  // R2
  bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni && bcast) |=> ($countones({in_q[0] == in_q[1], in_q[1] == in_q[2], in_q[2] == in_q[3]}) == 3));
endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
  import qdl_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_i,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  input  logic                     load_ni,
  input  logic                     ldac_i,
  input  logic                     clr_ni,
  output logic [CH_N*CODE_W-1:0]   code_o,
  output logic [WORD_W-1:0]        shift_o
);
  localparam int unsigned PIN_N = 6;
  logic [PIN_N-1:0] pins_raw, pins_s;
  logic [CH_N-1:0][CODE_W-1:0] out_w;

  assign pins_raw = {cs_i, sclk_i, sdi_i, load_ni, ldac_i, clr_ni};

  // idle levels: cs high, sclk high, load high, clear asserted
  qdl_sync #(.W(PIN_N), .RST_VAL(6'b110100)) u_sync (
    .clk_i, .rst_ni, .d_i(pins_raw), .q_o(pins_s)
  );

  qdl_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_i(pins_s[5]), .sclk_i(pins_s[4]), .sdi_i(pins_s[3]),
    .sh_o(shift_o)
  );

  qdl_bank u_bank (
    .clk_i, .rst_ni, .sh_i(shift_o),
    .load_ni(pins_s[2]), .ldac_i(pins_s[1]), .clr_ni(pins_s[0]),
    .out_o(out_w)
  );

  assign code_o = out_w;
endmodule

// File: tb/quad_dac_loader_test.sv
`timescale 1ns/1ps
module quad_dac_loader_test;
  logic clk = 0, rst_n = 0;
  logic cs = 1, sclk = 1, sdi = 0, load_n = 1, ldac = 0, clr_n = 1;
  logic [63:0] code;
  logic [23:0] shv;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [23:0] m_sh = '0;
  logic [15:0] m_in [4];
  logic [15:0] m_out [4];
  bit m_load = 0;

  always #4 clk = ~clk;

  quad_dac_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .load_ni(load_n), .ldac_i(ldac), .clr_ni(clr_n), .code_o(code), .shift_o(shv)
  );

  // word, expected outputs {ch3,ch2,ch1,ch0}
  localparam logic [87:0] VEC [6] = '{
    {24'h001234, 64'h0000_0000_0000_1234},
    {24'h40ABCD, 64'h0000_0000_ABCD_1234},
    {24'h808000, 64'h0000_8000_ABCD_1234},
    {24'hC07FFF, 64'h7FFF_8000_ABCD_1234},
    {24'h7F5A5A, 64'h5A5A_5A5A_5A5A_5A5A},
    {24'h9FFFFF, 64'h5A5A_FFFF_5A5A_5A5A}
  };

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] mout();
    return {m_out[3], m_out[2], m_out[1], m_out[0]};
  endfunction

  task automatic m_apply();
    for (int c = 0; c < 4; c++)
      if (m_sh[21] || m_sh[23:22] == 2'(c)) m_in[c] = m_sh[15:0];
  endtask

  task automatic m_shift(logic b);
    m_sh = {m_sh[22:0], b};
    if (m_load) m_apply();
  endtask

  task automatic send(logic [23:0] w);
    cs = 0; wt(4);
    for (int i = 23; i >= 0; i--) begin
      sclk = 0; sdi = w[i]; wt(4);
      sclk = 1; m_shift(w[i]); wt(4);
    end
    cs = 1; wt(4);
  endtask

  task automatic load_pulse();
    load_n = 0; m_load = 1; m_apply(); wt(6);
    load_n = 1; m_load = 0; wt(4);
  endtask

  task automatic ldac_pulse();
    ldac = 1; wt(6);
    for (int c = 0; c < 4; c++) m_out[c] = m_in[c];
    ldac = 0; wt(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] snap;
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_out[c] = '0; end
    wt(3); rst_n = 1; wt(6);
    chk("R8 reset outputs", code, 64'h0);
    chk("R3 reset shift", {40'h0, shv}, 64'h0);

    // R1 R2 table walk
    for (int k = 0; k < 6; k++) begin
      send(VEC[k][87:64]);
      chk("R3 shift word", {40'h0, shv}, {40'h0, VEC[k][87:64]});
      load_pulse();
      if (k == 3) chk("R7 hold before update", code, 64'h0000_8000_ABCD_1234);
      ldac_pulse();
      chk(k == 4 ? "R2 broadcast" : "R1 addressed load", code, VEC[k][63:0]);
    end

    // R4: cs high, sclk toggles
    snap = shv;
    sdi = 1;
    for (int i = 0; i < 5; i++) begin sclk = 0; wt(4); sclk = 1; wt(4); end
    chk("R4 cs high no shift", {40'h0, shv}, {40'h0, snap});

    // R5: cs rises with sclk low
    cs = 0; wt(4);
    for (int i = 23; i >= 0; i--) begin
      sclk = 0; sdi = 24'h412345 >> i; wt(4);
      sclk = 1; m_shift(sdi); wt(4);
    end
    sclk = 0; sdi = 1; wt(4);
    cs = 1; m_shift(1'b1); wt(4);
    sclk = 1; wt(4);
    chk("R5 extra bit", {40'h0, shv}, {40'h0, 24'h82468B});

    // R6: shifting with load low corrupts channels passed through
    load_n = 0; m_load = 1; m_apply(); wt(6);
    send(24'h003C3C);
    load_n = 1; m_load = 0; wt(4);
    ldac_pulse();
    chk("R6 transparent load", code, mout());
    chk("R6 last channel", {48'h0, code[15:0]}, 64'h3C3C);

    // R8: clear keeps shift register
    snap = shv;
    clr_n = 0; wt(6);
    for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_out[c] = '0; end
    chk("R8 clear outputs", code, 64'h0);
    clr_n = 1; wt(6);
    chk("R8 shift after clear edge", {40'h0, shv}, {40'h0, snap});
    ldac_pulse();
    chk("R8 inputs cleared", code, 64'h0);

    // R1 unused bits and channel 3 after clear
    send(24'hDF0F0F); load_pulse(); ldac_pulse();
    chk("R1 ch3 unused bits", code, 64'h0F0F_0000_0000_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule